// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block models a synchronous single-port static memory whose shared data bus can change direction between any two clock cycles with no idle cycle. Each enabled clock edge can accept one access, whether a read, a write or a deselect, so any mix of reads and writes runs at one transfer per clock. Every input is registered on the rising edge, and read data leaves through an output register.

Write data arrives on the bus later than its address. The command therefore moves through two address stages. The data phase of every access is the cycle between the first and the second enabled edges after its address. Write data is captured at that second edge and written into the array there. A read whose data phase begins while the write just before it is still waiting for its data takes that write's live bus bytes, merged byte by byte over the stored word. A two-bit burst counter lets a controller step through four consecutive words, in linear or interleaved order, without sending new addresses. A clock enable freezes the whole block. An asynchronous output enable can force the bus to high impedance.

Top module: `zbt_sram`

## Requirements
- R1: A read whose address is sampled at enabled edge k drives its word onto `dq` from just after enabled edge k+1 until enabled edge k+2. Write data for an address sampled at edge k is captured from `dq` at enabled edge k+2.
- R2: A read returns the word left by all earlier writes in issue order, with no idle cycle needed between any two accesses.
- R3: On a load cycle (`adv`=0) the block is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. An unselected load causes no write, and the bus stays at high impedance during its data phase.
- R4: A write updates only the bytes whose `byte_en` bit is 1. Bit i covers `dq[8i+7:8i]`.
- R5: The block never drives `dq` during the data phase of a write. While `oe_n`=1 the bus is at high impedance at once, without waiting for a clock.
- R6: A read issued on the cycle right after a write to the same address returns that write's enabled bytes merged over the stored word.
- R7: With `adv`=1 the block repeats the previous access type (read, write or deselect) at the next burst address. The chip enables and `wr` are ignored, and `byte_en` is sampled on every cycle.
- R8: The burst offset is (start+n) mod 4 when `lin_mode`=1 and start XOR n when `lin_mode`=0. Here start is `addr[1:0]` at the load and n counts the advances since it (n = 1, 2, 3, then wrapping to 0). The upper address bits stay as loaded.
- R9: With `clk_en`=0 an edge has no effect. The bus value, the pipeline, the burst counter and the array all hold, and a pending write waits for the next enabled edge.
- R10: A synchronous reset (`rst_n`=0) empties the pipeline. The bus is at high impedance during the first two data phases after reset, and `adv`=1 right after reset acts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 ignores the edge |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| wr | input | 1 | 1 = write, 0 = read on a load cycle |
| adv | input | 1 | 1 = advance burst, 0 = load new address and command |
| lin_mode | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| byte_en | input | DW/8 | Per-byte write select, active high |
| addr | input | AW | Word address |
| dq | inout | DW | Bidirectional data bus |

## Verification
The checker watches the control pipeline on every cycle. It confirms that a stalled edge leaves the output register and the drive flag unchanged, that unselected loads and advances after a deselect leave no valid access, that a read load turns the drive on two enabled edges later and a write load keeps it off, and that the drive is off right after reset. Data correctness can only come from the bench's scenarios. These cover byte merging, forwarding from a write on the previous cycle, linear and interleaved burst order, stalls in the middle of a data phase, and asynchronous output-enable gating. Each is compared against a reference memory kept in issue order.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_en,
  input  logic            cs0_n,
  input  logic            cs1,
  input  logic            cs2_n,
  input  logic            wr,
  input  logic            adv,
  input  logic            lin_mode,
  input  logic            oe_n,
  input  logic [DW/8-1:0] byte_en,
  input  logic [AW-1:0]   addr,
  inout  wire  [DW-1:0]   dq
);
  localparam int NB    = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          c1_v, c1_wr, c2_v, c2_wr, drv_q;
  logic [AW-1:0] c1_a, c2_a, base_a;
  logic [NB-1:0] c1_be, c2_be;
  logic [1:0]    start, cnt;
  logic [DW-1:0] dout_q, rd_word;

  wire          sel    = !cs0_n && cs1 && !cs2_n;
  wire [1:0]    cnt_nx = cnt + 2'd1;
  wire [1:0]    low_nx = lin_mode ? start + cnt_nx : start ^ cnt_nx;
  wire          op_v   = adv ? c1_v  : sel;
  wire          op_wr  = adv ? c1_wr : wr;
  wire [AW-1:0] op_a   = adv ? {base_a[AW-1:2], low_nx} : addr;
  wire          fwd    = c2_v && c2_wr && (c2_a == c1_a);

  assign dq = (drv_q && !oe_n) ? dout_q : {DW{1'bz}};

  always_comb begin
    rd_word = mem[c1_a];
    for (int b = 0; b < NB; b++)
      if (fwd && c2_be[b]) rd_word[b*8 +: 8] = dq[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_v  <= 1'b0;
      c2_v  <= 1'b0;
      drv_q <= 1'b0;
    end else if (clk_en) begin
      c1_v  <= op_v;
      c2_v  <= c1_v;
      drv_q <= c1_v && !c1_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en) begin
      c1_wr  <= op_wr;
      c1_a   <= op_a;
      c1_be  <= byte_en;
      c2_wr  <= c1_wr;
      c2_a   <= c1_a;
      c2_be  <= c1_be;
      dout_q <= rd_word;
      if (!adv) begin
        base_a <= addr;
        start  <= addr[1:0];
        cnt    <= 2'd0;
      end else begin
        cnt    <= cnt_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && clk_en && c2_v && c2_wr)
      for (int b = 0; b < NB; b++)
        if (c2_be[b]) mem[c2_a][b*8 +: 8] <= dq[b*8 +: 8];
  end
endmodule

module zbt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          adv,
  input logic          wr,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          c1_v,
  input logic          drv_q,
  input logic [DW-1:0] dout_q
);
  wire sel_p = !cs0_n && cs1 && !cs2_n;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(drv_q) && $stable(dout_q)));

  // R3
  deselect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && !sel_p) |=> !c1_v);

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && sel_p && !wr) ##1 clk_en |=> drv_q);

  // R5
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && sel_p && wr) ##1 clk_en |=> !drv_q);

  // R7
  adv_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && !c1_v) |=> !c1_v);

  // R10
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!drv_q && !c1_v));
endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv), .wr(wr),
  .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
  .c1_v(c1_v), .drv_q(drv_q), .dout_q(dout_q)
);

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1;
  logic cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, wr = 1'b0, adv = 1'b0;
  logic lin_mode = 1'b1, oe_n = 1'b0;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic          dq_en = 1'b0;
  logic [DW-1:0] dq_drv = '0;
  wire  [DW-1:0] dq;

  assign dq = dq_en ? dq_drv : {DW{1'bz}};
  always #5 clk = ~clk;

  zbt_sram #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .wr(wr), .adv(adv), .lin_mode(lin_mode), .oe_n(oe_n),
    .byte_en(byte_en), .addr(addr), .dq(dq)
  );

  int tests = 0, fails = 0, n = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic          part [DEPTH];
  logic          h_v [4], h_wr [4], h_fwd [4], h_bst [4];
  logic [AW-1:0] h_a [4];
  logic [NB-1:0] h_be [4];
  logic          b_v = 1'b0, b_wr = 1'b0, prev_en = 1'b1;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic en, logic ld, logic s0n, logic s1, logic s2n, logic w,
                      logic [NB-1:0] be, logic [AW-1:0] a, logic lm, logic oe);
    int d = n - 2;
    int di = (n + 2) % 4;
    logic dv, dw, ov, owr, obst;
    logic [AW-1:0] oa;
    logic [1:0] nc;
    string tag;
    @(negedge clk);
    clk_en = en; adv = !ld; cs0_n = s0n; cs1 = s1; cs2_n = s2n; wr = w;
    byte_en = be; addr = a; lin_mode = lm; oe_n = oe;
    dv = (d >= 0) && h_v[di];
    dw = dv && h_wr[di];
    dq_en = dw;
    dq_drv = $urandom;
    #1;
    if (dw) check("R5 write phase", dq, dq_drv);
    else if (dv && !oe) begin
      if (h_fwd[di]) tag = "R6";
      else if (part[h_a[di]]) tag = "R4";
      else if (h_bst[di]) tag = "R7 R8";
      else tag = "R1 R2";
      if (!prev_en) tag = {tag, " R9"};
      check(tag, dq, ref_mem[h_a[di]]);
    end else if (oe) check("R5 oe_n", dq, {DW{1'bz}});
    else if (d < 0) check("R10", dq, {DW{1'bz}});
    else check("R3 deselect", dq, {DW{1'bz}});
    if (ld) begin
      ov = !s0n && s1 && !s2n; owr = w; oa = a; nc = 2'd0; obst = 1'b0;
    end else begin
      nc = b_cnt + 2'd1; ov = b_v; owr = b_wr; obst = 1'b1;
      oa = {b_base[AW-1:2], lm ? b_base[1:0] + nc : b_base[1:0] ^ nc};
    end
    @(posedge clk);
    prev_en = en;
    if (en) begin
      if (dw) begin
        ref_mem[h_a[di]] = merge(ref_mem[h_a[di]], dq_drv, h_be[di]);
        part[h_a[di]] = (h_be[di] != '1);
      end
      h_fwd[n % 4] = ov && !owr && h_v[(n + 3) % 4] && h_wr[(n + 3) % 4] &&
                     (h_a[(n + 3) % 4] == oa) && (n >= 1);
      h_v[n % 4] = ov; h_wr[n % 4] = owr; h_a[n % 4] = oa;
      h_be[n % 4] = be; h_bst[n % 4] = obst;
      if (ld) b_base = a;
      b_cnt = nc; b_v = ov; b_wr = owr;
      n++;
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1, 1, 1, 0, 1, 0, '0, '0, 1, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin h_v[i] = 0; h_wr[i] = 0; h_fwd[i] = 0; h_bst[i] = 0; h_a[i] = '0; h_be[i] = '0; end
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = 'x; part[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R10: empty pipeline and advance after reset acts as deselect
    step(1, 0, 1, 1, 0, 0, '0, '0, 1, 0);
    step(1, 0, 1, 1, 0, 0, '0, '0, 1, 0);
    step(1, 1, 1, 0, 1, 0, '0, '0, 1, 0);
    // R2: fill the array with full-word writes
    for (int i = 0; i < DEPTH; i++) step(1, 1, 0, 1, 0, 1, '1, AW'(i), 1, 0);
    // R6: write then read the same address on the next cycle, partial mask
    step(1, 1, 0, 1, 0, 1, 4'b0101, 6'd9, 1, 0);
    step(1, 1, 0, 1, 0, 0, '0, 6'd9, 1, 0);
    // R7 R8: linear burst write from offset 1, interleaved burst read from offset 3
    step(1, 1, 0, 1, 0, 1, '1, 6'd17, 1, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 1, 0, '1, '0, 1, 0);
    step(1, 1, 0, 1, 0, 0, '0, 6'd19, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1, 1, '0, '0, 0, 0);
    // R9: stall in the middle of data phases
    step(1, 1, 0, 1, 0, 0, '0, 6'd3, 1, 0);
    step(1, 1, 0, 1, 0, 1, 4'b1000, 6'd3, 1, 0);
    step(0, 1, 0, 1, 0, 1, '1, 6'd5, 1, 0);
    step(0, 1, 0, 1, 0, 1, '1, 6'd5, 1, 0);
    step(1, 1, 0, 1, 0, 0, '0, 6'd3, 1, 0);
    idle(3);
    for (int i = 0; i < 3000; i++) begin
      logic allsel = ($urandom % 7) != 0;
      step(($urandom % 10) != 0, ($urandom % 3) != 0,
           allsel ? 1'b0 : 1'($urandom), allsel ? 1'b1 : 1'($urandom),
           allsel ? 1'b0 : 1'($urandom), 1'($urandom),
           ($urandom % 2) ? '1 : NB'($urandom),
           ($urandom % 2) ? AW'($urandom % 8) : AW'($urandom),
           (i / 200) % 2 == 0, ($urandom % 12) == 0);
    end
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule